// File: doc/BRIEF.md
# Converter Test Run Sequencer

This block steps a bank of converter cells through one fault-emulation run. It waits in idle. On an accepted start it latches the run settings and enters pre-charge. In pre-charge the cells' rectifiers run and their inverters stay blocked, while each cell reports the health of its DC bus. When the pre-charge time ends, the sequencer makes one decision. If every cell has answered and none reported a fault, it moves to the test phase. Otherwise it drops back to idle and raises a sticky error.

In the test phase both converter stages are enabled for the programmed run length. Inside that interval a fault window is opened at a programmed offset and held for a programmed length. Downstream logic uses this window to choose between the normal voltage settings and the fault settings. When the run length expires, the sequencer returns to idle with both stages blocked.

All timing is counted in millisecond ticks. A prescaler makes each tick from `TICK_CLKS` clock cycles, and the prescaler restarts on each accepted start. Time is therefore measured exactly from the start edge.

The states are:
- `SEQ_IDLE` (mode code 3).
- `SEQ_PRECHARGE` (mode code 1).
- `SEQ_TEST` (mode code 2).

The transitions are:
- start: idle to pre-charge.
- pass: pre-charge to test.
- fail: pre-charge to idle, with the error set.
- finish: test to idle.

Top module: `test_sequencer`

## Requirements
- R1: After reset, `mode` is 3 (idle), and `rect_en`, `inv_en`, `fault_win` and `err_flag` are all 0.
- R2: `start` is acted on only in idle. A start pulse during pre-charge or test changes neither the mode nor the timing of the current run.
- R3: An accepted start gives `mode`=1, `rect_en`=1 and `inv_en`=0 from the next clock edge. Pre-charge lasts exactly `PRECHARGE_MS` ticks, where one tick is `TICK_CLKS` clocks counted from the start edge.
- R4: At the end of pre-charge, if every cell has pulsed `cell_rpt_valid` with `cell_rpt_ok`=1 and no cell has reported `cell_rpt_ok`=0, the block enters `mode`=2 with `rect_en`=1 and `inv_en`=1.
- R5: If any cell never reported, or reported a bad status, the block instead goes to `mode`=3 with both enables at 0 and sets `err_flag`. `err_flag` stays set until the next accepted start clears it.
- R6: The test phase lasts `test_len_ms` ticks (values of at least 1). After that the block returns to `mode`=3 with both enables at 0 and `err_flag` at 0.
- R7: `fault_win` is 1 exactly during the test-phase ticks t (counted from 0) that satisfy `fault_at_ms` <= t < `fault_at_ms`+`fault_len_ms`. A length of 0 gives no window, and the window is cut off where the test phase ends.
- R8: `test_len_ms`, `fault_at_ms` and `fault_len_ms` are sampled at the accepted start. Later changes do not affect the current run.
- R9: Cell reports outside pre-charge are ignored. A bad report during the test phase neither aborts the run nor sets `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request; acted on in idle only |
| test_len_ms | input | MS_W | Test phase length in ticks |
| fault_at_ms | input | MS_W | Fault window offset into the test phase |
| fault_len_ms | input | MS_W | Fault window length in ticks |
| cell_rpt_valid | input | N_CELLS | One-cycle report strobe per cell |
| cell_rpt_ok | input | N_CELLS | DC-bus healthy flag per cell, qualified by its strobe |
| mode | output | 2 | 1 pre-charge, 2 test, 3 idle |
| rect_en | output | 1 | Rectifier enable for all cells |
| inv_en | output | 1 | Inverter enable for all cells |
| fault_win | output | 1 | Selects fault settings during the window |
| err_flag | output | 1 | Sticky pre-charge failure flag |

## Verification
Every output follows the state register and the tick counter directly, so each result is due on the clock edge that makes it happen. The mode and enables change on the start edge. The pre-charge verdict is due on the edge that is `PRECHARGE_MS`·`TICK_CLKS` clocks after the start edge. The fault window and the end of the run fall on the edges that are (`PRECHARGE_MS`+t)·`TICK_CLKS` clocks after the start edge. The bench counts the edges since the start edge and computes the expected mode, enables, window and error from that count alone. It samples on the falling clock edge after every rising edge, so every cycle of every run is compared, including the exact boundary cycles.

// File: rtl/tmseq_pkg.sv
package tmseq_pkg;
    // Encodings are visible on the mode port
    typedef enum logic [1:0] {
        SEQ_PRECHARGE = 2'd1,
        SEQ_TEST      = 2'd2,
        SEQ_IDLE      = 2'd3
    } seq_mode_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int TICK_CLKS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (clr)          cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST) && !clr;
endmodule

// File: rtl/ms_counter.sv
module ms_counter #(
    parameter int MS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick,
    output logic [MS_W-1:0] elapsed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         elapsed <= '0;
        else if (clr)                       elapsed <= '0;
        else if (tick && (elapsed != '1))   elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/cell_status.sv
module cell_status #(
    parameter int N_CELLS = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [N_CELLS-1:0] rpt_valid,
    input  logic [N_CELLS-1:0] rpt_ok,
    output logic               all_good
);
    logic [N_CELLS-1:0] seen;
    logic [N_CELLS-1:0] bad;

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen[c] <= 1'b0;
                bad[c]  <= 1'b0;
            end else if (clr) begin
                seen[c] <= 1'b0;
                bad[c]  <= 1'b0;
            end else if (en && rpt_valid[c]) begin
                seen[c] <= 1'b1;
                if (!rpt_ok[c]) bad[c] <= 1'b1;
            end
        end
    end

    assign all_good = (&seen) && !(|bad);

    // R9: collection only grows while pre-charge enables it
    assert_collect_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((seen & ~$past(seen)) != '0) |-> $past(en));
endmodule

// File: rtl/test_sequencer.sv
module test_sequencer
    import tmseq_pkg::*;
#(
    parameter int TICK_CLKS    = 50000,
    parameter int PRECHARGE_MS = 5000,
    parameter int N_CELLS      = 9,
    parameter int MS_W         = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MS_W-1:0]    test_len_ms,
    input  logic [MS_W-1:0]    fault_at_ms,
    input  logic [MS_W-1:0]    fault_len_ms,
    input  logic [N_CELLS-1:0] cell_rpt_valid,
    input  logic [N_CELLS-1:0] cell_rpt_ok,
    output logic [1:0]         mode,
    output logic               rect_en,
    output logic               inv_en,
    output logic               fault_win,
    output logic               err_flag
);
    localparam logic [MS_W-1:0] PRE_LAST = MS_W'(PRECHARGE_MS - 1);

    seq_mode_e st, nxt;
    logic [MS_W-1:0] elapsed;
    logic [MS_W-1:0] len_q, at_q, flen_q;
    logic            tick, all_good;
    logic            pre_clr, ctr_clr, stat_clr, latch, set_err, clr_err;
    logic [MS_W:0]   fend, elapsed_nx;

    tick_prescaler #(.TICK_CLKS(TICK_CLKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .tick(tick)
    );

    ms_counter #(.MS_W(MS_W)) u_ms (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .tick(tick), .elapsed(elapsed)
    );

    cell_status #(.N_CELLS(N_CELLS)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr(stat_clr), .en(st == SEQ_PRECHARGE),
        .rpt_valid(cell_rpt_valid), .rpt_ok(cell_rpt_ok), .all_good(all_good)
    );

    assign elapsed_nx = {1'b0, elapsed} + 1'b1;
    assign fend       = {1'b0, at_q} + {1'b0, flen_q};

    // transitions: start, pass, fail, finish
    always_comb begin
        nxt      = st;
        pre_clr  = 1'b0;
        ctr_clr  = 1'b0;
        stat_clr = 1'b0;
        latch    = 1'b0;
        set_err  = 1'b0;
        clr_err  = 1'b0;
        unique case (st)
            SEQ_IDLE: begin
                if (start) begin
                    nxt      = SEQ_PRECHARGE;
                    pre_clr  = 1'b1;
                    ctr_clr  = 1'b1;
                    stat_clr = 1'b1;
                    latch    = 1'b1;
                    clr_err  = 1'b1;
                end
            end
            SEQ_PRECHARGE: begin
                if (tick && (elapsed == PRE_LAST)) begin
                    ctr_clr = 1'b1;
                    if (all_good) begin
                        nxt = SEQ_TEST;
                    end else begin
                        nxt     = SEQ_IDLE;
                        set_err = 1'b1;
                    end
                end
            end
            SEQ_TEST: begin
                if (tick && (elapsed_nx >= {1'b0, len_q})) begin
                    nxt     = SEQ_IDLE;
                    ctr_clr = 1'b1;
                end
            end
            default: nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            err_flag <= 1'b0;
            len_q    <= '0;
            at_q     <= '0;
            flen_q   <= '0;
        end else begin
            st <= nxt;
            if (set_err)      err_flag <= 1'b1;
            else if (clr_err) err_flag <= 1'b0;
            if (latch) begin
                len_q  <= test_len_ms;
                at_q   <= fault_at_ms;
                flen_q <= fault_len_ms;
            end
        end
    end

    always_comb begin
        mode      = st;
        rect_en   = 1'b0;
        inv_en    = 1'b0;
        fault_win = 1'b0;
        unique case (st)
            SEQ_PRECHARGE: rect_en = 1'b1;
            SEQ_TEST: begin
                rect_en   = 1'b1;
                inv_en    = 1'b1;
                fault_win = (elapsed >= at_q) && ({1'b0, elapsed} < fend);
            end
            default: ;
        endcase
    end

    assert_inv_needs_rect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |-> rect_en);

    assert_window_in_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_win |-> (mode == 2'd2));

    assert_test_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2) && ($past(mode) != 2'd2)) |->
            (($past(mode) == 2'd1) && $past(all_good)));

    assert_err_from_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> ($past(mode) == 2'd1) && (mode == 2'd3));

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2) && start) |=> (mode != 2'd1));
endmodule

// File: tb/tb_test_sequencer.sv
module tb_test_sequencer;
    localparam int P   = 4;
    localparam int PRE = 6;
    localparam int NC  = 9;
    localparam int W   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  test_len_ms = '0, fault_at_ms = '0, fault_len_ms = '0;
    logic [NC-1:0] cell_rpt_valid = '0, cell_rpt_ok = '0;
    logic [1:0]    mode;
    logic          rect_en, inv_en, fault_win, err_flag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    test_sequencer #(.TICK_CLKS(P), .PRECHARGE_MS(PRE), .N_CELLS(NC), .MS_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .test_len_ms(test_len_ms), .fault_at_ms(fault_at_ms), .fault_len_ms(fault_len_ms),
        .cell_rpt_valid(cell_rpt_valid), .cell_rpt_ok(cell_rpt_ok),
        .mode(mode), .rect_en(rect_en), .inv_en(inv_en),
        .fault_win(fault_win), .err_flag(err_flag)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected outputs n edges after the start edge, from the requirements
    function automatic void model(int n, int tot, int fs, int fl, bit fail,
                                  output int em, output int er, output int ei,
                                  output int ef, output int ee, output string tag);
        int m = n / P;
        int t;
        ef = 0;
        if (m < PRE) begin
            em = 1; er = 1; ei = 0; ee = 0; tag = "R3 R2";
        end else if (fail) begin
            em = 3; er = 0; ei = 0; ee = 1; tag = "R5";
        end else begin
            t = m - PRE;
            if (t < tot) begin
                em = 2; er = 1; ei = 1; ee = 0; tag = "R4 R8 R9";
                ef = (t >= fs && t < fs + fl) ? 1 : 0;
            end else begin
                em = 3; er = 0; ei = 0; ee = 0; tag = "R6";
            end
        end
    endfunction

    // kind: 0 all healthy, 1 one cell silent, 2 one cell reports bad
    task automatic run_case(int tot, int fs, int fl, int kind);
        bit fail = (kind != 0);
        int last = fail ? PRE * P + 3 : (PRE + tot) * P + 3;
        int em, er, ei, ef, ee;
        string tag;
        @(negedge clk);
        test_len_ms  = W'(tot);
        fault_at_ms  = W'(fs);
        fault_len_ms = W'(fl);
        start = 1'b1;
        for (int n = 0; n <= last; n++) begin
            @(negedge clk);
            start = 1'b0;
            cell_rpt_valid = '0;
            model(n, tot, fs, fl, fail, em, er, ei, ef, ee, tag);
            chk({tag, " mode"}, int'(mode), em);
            chk({tag, " rect_en"}, int'(rect_en), er);
            chk({tag, " inv_en"}, int'(inv_en), ei);
            chk("R7 fault_win", int'(fault_win), ef);
            chk("R5 err_flag", int'(err_flag), ee);
            if (n == 0) begin
                cell_rpt_valid = '1;
                cell_rpt_ok    = '1;
                if (kind == 1) cell_rpt_valid[4] = 1'b0;
                if (kind == 2) cell_rpt_ok[7] = 1'b0;
            end
            if (n == 2) start = 1'b1;                 // R2 during pre-charge
            if (!fail && n == PRE * P + 1) begin      // R8, R9, R2 during test
                test_len_ms  = W'(1);
                fault_at_ms  = W'(0);
                fault_len_ms = W'(0);
                cell_rpt_valid = '1;
                cell_rpt_ok    = '0;
                start = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = $urandom(32'd20517);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", int'(mode), 3);
        chk("R1 rect_en", int'(rect_en), 0);
        chk("R1 inv_en", int'(inv_en), 0);
        chk("R1 fault_win", int'(fault_win), 0);
        chk("R1 err_flag", int'(err_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", int'(mode), 3);

        run_case(12, 6, 6, 0);   // fault at halfway
        run_case(8, 2, 0, 0);    // R7 zero length
        run_case(5, 3, 9, 0);    // R7 window cut at test end
        run_case(1, 0, 1, 0);    // shortest run
        run_case(10, 0, 4, 1);   // R5 silent cell
        run_case(10, 4, 2, 0);   // R5 error cleared by new start
        run_case(10, 4, 2, 2);   // R5 bad cell
        run_case(7, 7, 3, 0);    // window starts at end, never opens

        for (int i = 0; i < 20; i++) begin
            int tot  = 1 + int'($urandom % 20);
            int fs   = int'($urandom % (tot + 2));
            int fl   = int'($urandom % 12);
            int kind = int'($urandom % 6);
            if (kind > 2) kind = 0;
            run_case(tot, fs, fl, kind);
        end
        if (seed == 0) $display("seed zero");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule